// File: doc/BRIEF.md
# Multi-Channel Successive-Approximation Scan Controller

This block is the digital half of an eight-input successive-approximation converter. A trigger starts a scan. The source of that trigger is chosen from a software strobe, a rising edge on an asynchronous pin, or a timer pulse. The controller then visits every enabled channel, lowest number first. For each channel it points the analog multiplexer at the input and waits a programmable sample time. It then resolves the value one bit per clock. Each trial code goes to an external DAC, and the decision comes back on a comparator input.

Every result is written to two places: a register shared by all channels, which also records the channel number, and a register that belongs to the converted channel. A one-cycle request strobe for a DMA engine accompanies each store. Status flags record results that have not been read yet, results that were overwritten, and triggers that were lost.

In sleep mode the analog part is kept powered down while the controller is idle. A trigger wakes it, a startup delay is waited out, all enabled channels are converted, and the analog part powers down again without software help. Resolution is either ten bits or eight bits.

Top module: `adc_scan_ctrl`

## Requirements
- R1: After reset the following are all zero: `busy`, `drdy`, `eoc`, `chan_ovr`, `trig_ovr`, `dma_req` and `last_data`.
- R2: `cfg_trig_src` selects the trigger source: 0 = `sw_start` high, 1 = rising edge of `ext_trig` after a two-flop synchronizer, 2 = `tmr_trig` high, 3 = no source. A source that is not selected starts nothing.
- R3: A scan converts the enabled channels (bit i of `cfg_chan_en` enables channel i) in ascending order and skips disabled ones. A trigger while no channel is enabled starts nothing.
- R4: A scan keeps `busy` high for exactly W + n*(H+1+B) cycles. W is `cfg_startup`+1 in sleep mode and 0 otherwise, n is the number of enabled channels, H is `cfg_sample`, and B is 10, or 8 when `cfg_low_res`=1.
- R5: The search tests bits from MSB to LSB, one per clock. A bit is kept when `cmp_in` is 1, which means the input is at or above `sar_trial`. The result is the largest code whose trial does not exceed the input. `sar_trial` is 0 outside a scan.
- R6: With `cfg_low_res`=1 only eight decisions are made, on `sar_trial[9:2]`, with `sar_trial[1:0]`=0. The 8-bit result is stored in bits 7:0, and the upper bits are zero.
- R7: Each result is written to `last_data`, with the channel number in `last_chan`, and to that channel's own register. The channel's register is read on `chan_data` by setting `rd_idx`.
- R8: `dma_req` is high for exactly one cycle per stored result. That cycle directly follows the store.
- R9: `pwr_on` is high throughout a scan. While idle it is low in sleep mode (`cfg_sleep`=1) and high otherwise.
- R10: A trigger from the selected source during a scan is dropped and sets `trig_ovr`. The flag stays set until `rd_status` clears it.
- R11: A store sets `drdy` and `eoc[ch]`. `rd_last` clears `drdy`, and `rd_chan` clears `eoc[rd_idx]`. If a store and a clear fall in the same cycle, the store wins.
- R12: A store to a channel whose `eoc` bit is still set, and which is not being read in that cycle, sets `chan_ovr[ch]`. `rd_status` clears all `chan_ovr` bits.
- R13: During the sample and conversion phases, `mux_sel` shows the channel being converted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_chan_en | input | 8 | Channel enable mask |
| cfg_trig_src | input | 2 | Trigger source select |
| cfg_low_res | input | 1 | 1 = 8-bit resolution |
| cfg_sleep | input | 1 | 1 = power down between scans |
| cfg_startup | input | 8 | Wake-up delay in cycles (minus one) |
| cfg_sample | input | 8 | Sample time in cycles (minus one) |
| sw_start | input | 1 | Software trigger strobe |
| ext_trig | input | 1 | Asynchronous trigger pin |
| tmr_trig | input | 1 | Timer trigger pulse |
| cmp_in | input | 1 | Comparator decision, 1 = input at or above trial |
| rd_last | input | 1 | Read strobe of the shared result |
| rd_chan | input | 1 | Read strobe of the channel register |
| rd_idx | input | 3 | Channel register index |
| rd_status | input | 1 | Clears overrun flags |
| mux_sel | output | 3 | Analog multiplexer select |
| sar_trial | output | 10 | Trial code to the DAC |
| pwr_on | output | 1 | Analog power enable |
| busy | output | 1 | Scan in progress |
| last_data | output | 10 | Shared last result |
| last_chan | output | 3 | Channel of the last result |
| drdy | output | 1 | Unread shared result |
| chan_data | output | 10 | Channel register selected by rd_idx |
| eoc | output | 8 | Per-channel unread result flags |
| chan_ovr | output | 8 | Per-channel overwrite flags |
| trig_ovr | output | 1 | Trigger lost during a scan |
| dma_req | output | 1 | DMA request pulse |

## Verification
The store of a result and the software read that clears the ready flags can land in the same clock. This is provoked by holding `rd_last` and `rd_chan` (pointing at the converted channel) high for the whole of two scans. Every store then meets a clear. Afterwards `drdy` and the channel's `eoc` bit must still be set, and `chan_ovr` must stay clear even though the register was overwritten. A second collision, a trigger arriving mid-scan, is judged by counting the requests: they must match one scan only, and `trig_ovr` must be set.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

    typedef enum logic [1:0] {
        TRG_SOFT  = 2'd0,
        TRG_PIN   = 2'd1,
        TRG_TIMER = 2'd2,
        TRG_NONE  = 2'd3
    } trig_src_e;

    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'd0,
        SEQ_WAKE   = 2'd1,
        SEQ_SAMPLE = 2'd2,
        SEQ_CONV   = 2'd3
    } seq_state_e;

endpackage

// File: rtl/adc_trig_sel.sv
module adc_trig_sel
    import adc_scan_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  trig_src_e src,
    input  logic      sw_start,
    input  logic      ext_pin,
    input  logic      tmr_evt,
    output logic      trig_evt
);
    localparam int TOP = SYNC_STAGES - 1;

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   prev;
    } trg_t;

    trg_t trg_d, trg_q;
    logic pin_rise;

    always_comb begin
        trg_d      = trg_q;
        trg_d.sync = {trg_q.sync[TOP-1:0], ext_pin};
        trg_d.prev = trg_q.sync[TOP];
        pin_rise   = trg_q.sync[TOP] & ~trg_q.prev;
        unique case (src)
            TRG_SOFT:  trig_evt = sw_start;
            TRG_PIN:   trig_evt = pin_rise;
            TRG_TIMER: trig_evt = tmr_evt;
            default:   trig_evt = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trg_q <= '0;
        else        trg_q <= trg_d;
    end

endmodule

// File: rtl/adc_sar_core.sv
module adc_sar_core #(
    parameter int RES_W = 10,
    parameter int LOW_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             low_res,
    input  logic             cmp_in,
    output logic [RES_W-1:0] trial,
    output logic             last,
    output logic [RES_W-1:0] result
);
    localparam int IDX_W = $clog2(RES_W);
    localparam int DROP  = RES_W - LOW_W;

    typedef struct packed {
        logic             active;
        logic [IDX_W-1:0] idx;
        logic [RES_W-1:0] acc;
    } sar_t;

    sar_t sar_d, sar_q;
    logic [IDX_W-1:0] stop_idx;
    logic [RES_W-1:0] kept;

    always_comb begin
        sar_d    = sar_q;
        stop_idx = low_res ? IDX_W'(DROP) : '0;
        trial    = '0;
        last     = 1'b0;
        if (sar_q.active) begin
            trial = sar_q.acc | (RES_W'(1) << sar_q.idx);
        end
        kept = cmp_in ? trial : sar_q.acc;
        if (sar_q.active) begin
            last      = (sar_q.idx == stop_idx);
            sar_d.acc = kept;
            if (last) sar_d.active = 1'b0;
            else      sar_d.idx    = sar_q.idx - 1'b1;
        end
        if (start) begin
            sar_d.active = 1'b1;
            sar_d.idx    = IDX_W'(RES_W - 1);
            sar_d.acc    = '0;
        end
        result = low_res ? (kept >> DROP) : kept;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sar_q <= '0;
        else        sar_q <= sar_d;
    end

endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank #(
    parameter int NCH   = 8,
    parameter int RES_W = 10,
    localparam int CH_W = $clog2(NCH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CH_W-1:0]  wr_ch,
    input  logic [RES_W-1:0] wr_data,
    input  logic             rd_last,
    input  logic             rd_chan,
    input  logic [CH_W-1:0]  rd_idx,
    input  logic             rd_status,
    output logic [RES_W-1:0] chan_data,
    output logic [RES_W-1:0] last_data,
    output logic [CH_W-1:0]  last_chan,
    output logic             drdy,
    output logic [NCH-1:0]   eoc,
    output logic [NCH-1:0]   chan_ovr,
    output logic             dma_req
);
    typedef struct packed {
        logic [NCH-1:0][RES_W-1:0] mem;
        logic [RES_W-1:0]          last;
        logic [CH_W-1:0]           lch;
        logic                      drdy;
        logic [NCH-1:0]            eoc;
        logic [NCH-1:0]            ovr;
        logic                      dma;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d     = bank_q;
        bank_d.dma = wr_en;
        if (rd_last)   bank_d.drdy        = 1'b0;
        if (rd_chan)   bank_d.eoc[rd_idx] = 1'b0;
        if (rd_status) bank_d.ovr         = '0;
        if (wr_en) begin
            bank_d.mem[wr_ch] = wr_data;
            bank_d.last       = wr_data;
            bank_d.lch        = wr_ch;
            bank_d.drdy       = 1'b1;
            bank_d.eoc[wr_ch] = 1'b1;
            if (bank_q.eoc[wr_ch] && !(rd_chan && rd_idx == wr_ch)) begin
                bank_d.ovr[wr_ch] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    assign chan_data = bank_q.mem[rd_idx];
    assign last_data = bank_q.last;
    assign last_chan = bank_q.lch;
    assign drdy      = bank_q.drdy;
    assign eoc       = bank_q.eoc;
    assign chan_ovr  = bank_q.ovr;
    assign dma_req   = bank_q.dma;

endmodule

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl
    import adc_scan_pkg::*;
#(
    parameter int NCH   = 8,
    parameter int RES_W = 10,
    parameter int LOW_W = 8,
    parameter int DLY_W = 8,
    localparam int CH_W = $clog2(NCH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NCH-1:0]   cfg_chan_en,
    input  logic [1:0]       cfg_trig_src,
    input  logic             cfg_low_res,
    input  logic             cfg_sleep,
    input  logic [DLY_W-1:0] cfg_startup,
    input  logic [DLY_W-1:0] cfg_sample,
    input  logic             sw_start,
    input  logic             ext_trig,
    input  logic             tmr_trig,
    input  logic             cmp_in,
    input  logic             rd_last,
    input  logic             rd_chan,
    input  logic [CH_W-1:0]  rd_idx,
    input  logic             rd_status,
    output logic [CH_W-1:0]  mux_sel,
    output logic [RES_W-1:0] sar_trial,
    output logic             pwr_on,
    output logic             busy,
    output logic [RES_W-1:0] last_data,
    output logic [CH_W-1:0]  last_chan,
    output logic             drdy,
    output logic [RES_W-1:0] chan_data,
    output logic [NCH-1:0]   eoc,
    output logic [NCH-1:0]   chan_ovr,
    output logic             trig_ovr,
    output logic             dma_req
);
    typedef struct packed {
        seq_state_e       st;
        logic [DLY_W-1:0] cnt;
        logic [CH_W-1:0]  chan;
        logic [NCH-1:0]   en;
        logic             low_res;
        logic             trig_ovr;
    } ctrl_t;

    ctrl_t ctl_d, ctl_q;

    logic             trig_evt;
    logic             sar_start;
    logic             sar_last;
    logic [RES_W-1:0] sar_result;
    logic             wr_en;
    logic [CH_W:0]    nxt;
    logic             low_res_q;

    // lowest enabled channel at or above 'from'; MSB flags a hit
    function automatic logic [CH_W:0] next_enabled(input logic [NCH-1:0] mask,
                                                   input int from);
        logic [CH_W:0] r;
        r = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (mask[i] && i >= from) r = {1'b1, CH_W'(i)};
        end
        return r;
    endfunction

    adc_trig_sel #(.SYNC_STAGES(2)) u_trig (
        .clk      (clk),
        .rst_n    (rst_n),
        .src      (trig_src_e'(cfg_trig_src)),
        .sw_start (sw_start),
        .ext_pin  (ext_trig),
        .tmr_evt  (tmr_trig),
        .trig_evt (trig_evt)
    );

    adc_sar_core #(.RES_W(RES_W), .LOW_W(LOW_W)) u_sar (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (sar_start),
        .low_res (ctl_q.low_res),
        .cmp_in  (cmp_in),
        .trial   (sar_trial),
        .last    (sar_last),
        .result  (sar_result)
    );

    adc_result_bank #(.NCH(NCH), .RES_W(RES_W)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_ch     (ctl_q.chan),
        .wr_data   (sar_result),
        .rd_last   (rd_last),
        .rd_chan   (rd_chan),
        .rd_idx    (rd_idx),
        .rd_status (rd_status),
        .chan_data (chan_data),
        .last_data (last_data),
        .last_chan (last_chan),
        .drdy      (drdy),
        .eoc       (eoc),
        .chan_ovr  (chan_ovr),
        .dma_req   (dma_req)
    );

    always_comb begin
        ctl_d     = ctl_q;
        sar_start = 1'b0;
        wr_en     = 1'b0;
        nxt       = '0;
        unique case (ctl_q.st)
            SEQ_IDLE: begin
                if (trig_evt && |cfg_chan_en) begin
                    nxt           = next_enabled(cfg_chan_en, 0);
                    ctl_d.en      = cfg_chan_en;
                    ctl_d.low_res = cfg_low_res;
                    ctl_d.chan    = nxt[CH_W-1:0];
                    if (cfg_sleep) begin
                        ctl_d.st  = SEQ_WAKE;
                        ctl_d.cnt = cfg_startup;
                    end else begin
                        ctl_d.st  = SEQ_SAMPLE;
                        ctl_d.cnt = cfg_sample;
                    end
                end
            end
            SEQ_WAKE: begin
                if (ctl_q.cnt == '0) begin
                    ctl_d.st  = SEQ_SAMPLE;
                    ctl_d.cnt = cfg_sample;
                end else begin
                    ctl_d.cnt = ctl_q.cnt - 1'b1;
                end
            end
            SEQ_SAMPLE: begin
                if (ctl_q.cnt == '0) begin
                    ctl_d.st  = SEQ_CONV;
                    sar_start = 1'b1;
                end else begin
                    ctl_d.cnt = ctl_q.cnt - 1'b1;
                end
            end
            SEQ_CONV: begin
                if (sar_last) begin
                    wr_en = 1'b1;
                    nxt   = next_enabled(ctl_q.en, int'(ctl_q.chan) + 1);
                    if (nxt[CH_W]) begin
                        ctl_d.chan = nxt[CH_W-1:0];
                        ctl_d.st   = SEQ_SAMPLE;
                        ctl_d.cnt  = cfg_sample;
                    end else begin
                        ctl_d.st   = SEQ_IDLE;
                    end
                end
            end
            default: ctl_d.st = SEQ_IDLE;
        endcase
        if (rd_status) ctl_d.trig_ovr = 1'b0;
        if (ctl_q.st != SEQ_IDLE && trig_evt) ctl_d.trig_ovr = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{st: SEQ_IDLE, default: '0};
        else        ctl_q <= ctl_d;
    end

    assign busy      = (ctl_q.st != SEQ_IDLE);
    assign pwr_on    = busy | ~cfg_sleep;
    assign mux_sel   = ctl_q.chan;
    assign trig_ovr  = ctl_q.trig_ovr;
    assign low_res_q = ctl_q.low_res;

endmodule

// File: rtl/adc_scan_chk.sv
module adc_scan_chk #(
    parameter int NCH   = 8,
    parameter int RES_W = 10,
    parameter int CH_W  = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             pwr_on,
    input logic [RES_W-1:0] sar_trial,
    input logic             low_res_q,
    input logic             dma_req,
    input logic             drdy,
    input logic [NCH-1:0]   eoc,
    input logic [CH_W-1:0]  last_chan,
    input logic             trig_ovr,
    input logic             rd_status
);
    AST_DMA_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |=> !dma_req); // R8

    AST_SCAN_POWERED: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> pwr_on); // R9

    AST_TRIAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> sar_trial == '0); // R5

    AST_COARSE_TRIAL: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && low_res_q) |-> sar_trial[1:0] == 2'b00); // R6

    AST_STORE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |-> (drdy && eoc[last_chan])); // R11

    AST_TRIG_OVR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_ovr && !rd_status) |=> trig_ovr); // R10

endmodule

bind adc_scan_ctrl adc_scan_chk #(.NCH(NCH), .RES_W(RES_W), .CH_W(CH_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .pwr_on    (pwr_on),
    .sar_trial (sar_trial),
    .low_res_q (low_res_q),
    .dma_req   (dma_req),
    .drdy      (drdy),
    .eoc       (eoc),
    .last_chan (last_chan),
    .trig_ovr  (trig_ovr),
    .rd_status (rd_status)
);

// File: tb/tb_adc_scan_ctrl.sv
module tb_adc_scan_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] cfg_chan_en = '0;
    logic [1:0] cfg_trig_src = '0;
    logic       cfg_low_res = 1'b0;
    logic       cfg_sleep = 1'b0;
    logic [7:0] cfg_startup = '0;
    logic [7:0] cfg_sample = '0;
    logic       sw_start = 1'b0;
    logic       ext_trig = 1'b0;
    logic       tmr_trig = 1'b0;
    logic       cmp_in;
    logic       rd_last = 1'b0;
    logic       rd_chan = 1'b0;
    logic [2:0] rd_idx = '0;
    logic       rd_status = 1'b0;
    logic [2:0] mux_sel;
    logic [9:0] sar_trial;
    logic       pwr_on, busy, drdy, trig_ovr, dma_req;
    logic [9:0] last_data, chan_data;
    logic [2:0] last_chan;
    logic [7:0] eoc, chan_ovr;

    logic [9:0] vin [8];
    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    assign cmp_in = (vin[mux_sel] >= sar_trial);

    adc_scan_ctrl dut (.*);

    task automatic chk(input string req, input string what, input int act, input int expv);
        total++;
        if (act != expv) begin
            bad++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, expv);
        end
    endtask

    function automatic int exp_code(input logic [9:0] v, input bit low);
        return low ? int'(v >> 2) : int'(v);
    endfunction

    function automatic int exp_busy(input int n, input int s, input int h,
                                    input bit slp, input bit low);
        return (slp ? s + 1 : 0) + n * (h + 1 + (low ? 8 : 10));
    endfunction

    // one scan with monitoring; src 0/1/2 fires the matching input
    task automatic run_scan(input logic [7:0] en, input int src, input bit slp,
                            input bit low, input int s, input int h,
                            input bit hold, input int hold_idx, input bit extra);
        int order[8];
        int n = 0;
        int k = 0;
        int bcnt = 0;
        int mux_err = 0;
        int pwr_err = 0;
        int trial_err = 0;
        int dat_err = 0;
        int ord_err = 0;
        bit seen = 0;
        for (int i = 0; i < 8; i++) if (en[i]) begin order[n] = i; n++; end
        @(negedge clk);
        cfg_chan_en = en; cfg_trig_src = 2'(src); cfg_sleep = slp;
        cfg_low_res = low; cfg_startup = 8'(s); cfg_sample = 8'(h);
        @(negedge clk);
        if (hold) begin rd_last = 1; rd_chan = 1; rd_idx = 3'(hold_idx); end
        if (src == 0) sw_start = 1;
        if (src == 1) ext_trig = 1;
        if (src == 2) tmr_trig = 1;
        for (int cyc = 0; cyc < 4000; cyc++) begin
            @(negedge clk);
            sw_start = 0; tmr_trig = 0;
            if (cyc == 3) ext_trig = 0;
            if (extra && cyc == 5) sw_start = 1;
            if (dma_req) begin
                if (k < n) begin
                    if (int'(last_chan) != order[k]) ord_err++;
                    if (int'(last_data) != exp_code(vin[order[k]], low)) dat_err++;
                end else ord_err++;
                k++;
            end
            if (busy) begin
                seen = 1; bcnt++;
                if (!pwr_on) pwr_err++;
                if (k < n && int'(mux_sel) != order[k]) mux_err++;
                if (low && sar_trial[1:0] != 2'b00) trial_err++;
            end else if (seen && cyc > 3) break;
        end
        rd_last = 0; rd_chan = 0;
        chk("R3", "scan order errors", ord_err, 0);
        chk("R7", "last_data errors", dat_err, 0);
        chk("R8", "request count", k, n);
        chk("R4", "busy cycles", bcnt, exp_busy(n, s, h, slp, low));
        chk("R13", "mux select errors", mux_err, 0);
        chk("R9", "power drops in scan", pwr_err, 0);
        chk("R9", "idle power", int'(pwr_on), slp ? 0 : 1);
        if (low) chk("R6", "coarse trial errors", trial_err, 0);
    endtask

    task automatic read_chan(input int i, output logic [9:0] v);
        @(negedge clk);
        rd_idx = 3'(i); rd_chan = 1;
        #1 v = chan_data;
        @(negedge clk);
        rd_chan = 0;
    endtask

    task automatic clear_all();
        @(negedge clk);
        rd_last = 1; rd_status = 1;
        for (int i = 0; i < 8; i++) begin
            rd_idx = 3'(i); rd_chan = 1;
            @(negedge clk);
        end
        rd_last = 0; rd_status = 0; rd_chan = 0;
    endtask

    task automatic check_chans(input logic [7:0] en, input bit low);
        logic [9:0] v;
        for (int i = 0; i < 8; i++) begin
            if (en[i]) begin
                read_chan(i, v);
                chk("R7", $sformatf("channel %0d register", i), int'(v), exp_code(vin[i], low));
            end
        end
    endtask

    task automatic quiet(input string req, input string what);
        int hits = 0;
        for (int c = 0; c < 12; c++) begin
            @(negedge clk);
            sw_start = 0; tmr_trig = 0; ext_trig = 0;
            if (busy) hits++;
        end
        chk(req, what, hits, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: got running expected finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4321));
        for (int i = 0; i < 8; i++) vin[i] = 10'(i * 97 + 5);
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "busy", int'(busy), 0);
        chk("R1", "drdy", int'(drdy), 0);
        chk("R1", "eoc", int'(eoc), 0);
        chk("R1", "chan_ovr", int'(chan_ovr), 0);
        chk("R1", "trig_ovr", int'(trig_ovr), 0);
        chk("R1", "dma_req", int'(dma_req), 0);
        chk("R1", "last_data", int'(last_data), 0);

        // R3 trigger with no channel enabled
        cfg_chan_en = 8'h00; cfg_trig_src = 2'd0;
        @(negedge clk); sw_start = 1;
        quiet("R3", "scan with empty mask");
        chk("R3", "trig_ovr after empty trigger", int'(trig_ovr), 0);

        // R2 unselected sources
        cfg_chan_en = 8'hFF; cfg_trig_src = 2'd3;
        @(negedge clk); sw_start = 1; ext_trig = 1; tmr_trig = 1;
        quiet("R2", "scan with source off");
        cfg_trig_src = 2'd1;
        @(negedge clk); sw_start = 1; tmr_trig = 1;
        quiet("R2", "pin selected, other strobes");
        cfg_trig_src = 2'd0;
        @(negedge clk); ext_trig = 1; tmr_trig = 1;
        quiet("R2", "soft selected, pin and timer");

        // R5 boundary inputs, all channels, sleep mode
        vin[0] = 10'd0; vin[1] = 10'd1023; vin[2] = 10'd512; vin[3] = 10'd511;
        run_scan(8'hFF, 0, 1, 0, 3, 2, 0, 0, 0);
        check_chans(8'hFF, 0);
        chk("R5", "trial outside scan", int'(sar_trial), 0);
        clear_all();

        // R6 low resolution
        vin[4] = 10'd3; vin[5] = 10'd1023; vin[6] = 10'd4;
        run_scan(8'h70, 2, 0, 1, 0, 1, 0, 0, 0);
        check_chans(8'h70, 1);
        chk("R6", "upper bits in 8-bit mode", int'(last_data[9:8]), 0);
        clear_all();

        // R3 skipping with sparse mask via pin trigger
        run_scan(8'h91, 1, 0, 0, 0, 0, 0, 0, 0);
        check_chans(8'h91, 0);
        clear_all();

        // R10 trigger during a scan
        run_scan(8'h0A, 0, 0, 0, 0, 4, 0, 0, 1);
        chk("R10", "trig_ovr set", int'(trig_ovr), 1);
        @(negedge clk); rd_status = 1;
        @(negedge clk); rd_status = 0;
        chk("R10", "trig_ovr cleared", int'(trig_ovr), 0);
        clear_all();

        // R12 overwrite without read
        run_scan(8'h04, 0, 0, 0, 0, 0, 0, 0, 0);
        chk("R12", "no overrun after first", int'(chan_ovr), 0);
        run_scan(8'h04, 0, 0, 0, 0, 0, 0, 0, 0);
        chk("R12", "overrun after second", int'(chan_ovr), 8'h04);
        @(negedge clk); rd_status = 1;
        @(negedge clk); rd_status = 0;
        chk("R12", "overrun cleared", int'(chan_ovr), 0);
        clear_all();

        // R11 store and clear in the same cycle
        run_scan(8'h20, 0, 0, 0, 1, 1, 1, 5, 0);
        run_scan(8'h20, 0, 0, 0, 1, 1, 1, 5, 0);
        chk("R11", "drdy after collision", int'(drdy), 1);
        chk("R11", "eoc after collision", int'(eoc), 8'h20);
        chk("R12", "no overrun when read", int'(chan_ovr), 0);
        @(negedge clk); rd_last = 1;
        @(negedge clk); rd_last = 0;
        chk("R11", "drdy cleared by read", int'(drdy), 0);
        @(negedge clk); rd_idx = 3'd5; rd_chan = 1;
        @(negedge clk); rd_chan = 0;
        chk("R11", "eoc cleared by read", int'(eoc), 0);

        // random scans
        for (int it = 0; it < 24; it++) begin
            logic [7:0] en;
            en = 8'($urandom_range(255, 1));
            for (int i = 0; i < 8; i++) vin[i] = 10'($urandom_range(1023, 0));
            run_scan(en, int'($urandom_range(2, 0)), bit'($urandom_range(1, 0)),
                     bit'($urandom_range(1, 0)), int'($urandom_range(7, 0)),
                     int'($urandom_range(7, 0)), 0, 0, 0);
            check_chans(en, cfg_low_res);
            chk("R11", "eoc after reading all", int'(eoc & en), 0);
            clear_all();
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule